// File: doc/BRIEF.md
# Frame Sync Window Countdown

This block is the vertical timebase of an interlaced 625-line deflection controller. It counts half-lines (32 µs steps at a 15.625 kHz line rate) from the start of each frame. It accepts a detected vertical sync only inside a search window, and it drives the vertical output pulse. It also produces two service strobes for the line phase-locked loop: a select for the short time constant and an inhibit.

A sync seen inside the window is held and acted on at the next half-line tick, so that frames always start on the half-line grid and odd and even fields stay apart. A sync outside the window has no effect. If no sync arrives, the counter restarts by itself at the far edge of the window. The far edge depends on whether video has been identified: with no video it is short, so the timebase catches a signal quickly; with video it is wide, to tolerate unstable sources. Each restart also records whether it fell at a line start or in the middle of a line.

Top module: `fsw_frame_timer`

## Requirements
- R1: While `rst` is high at a clock edge, the block clears `frame_pos` to 0 and drives `vdrive`, `pll_short`, `pll_inhibit`, `field_odd` and `win_open` low after that edge.
- R2: `frame_pos` rises by one on every clock edge at which `half_tick` is high, and it holds its value on every other edge, except at a restart.
- R3: With `vid_ok` low, `win_open` is high exactly for `frame_pos` 496 to 627 (lines 248 to 314). A `vsync_det` pulse while `win_open` is high restarts the frame at the next `half_tick`: after that tick `frame_pos` is 0.
- R4: With `vid_ok` high, `win_open` is high exactly for `frame_pos` 496 to 703 (lines 248 to 352), with the same restart behaviour.
- R5: A `vsync_det` pulse while `win_open` is low is ignored, and the frame runs on.
- R6: When no sync has been accepted, the `half_tick` seen at `frame_pos` 627 (`vid_ok` low) or 703 (`vid_ok` high) restarts the frame. The period is therefore 628 or 704 half-lines.
- R7: Every restart raises `vdrive`, which stays high for exactly 21 half-ticks. It falls on the tick that takes `frame_pos` from 20 to 21.
- R8: `pll_short` is high whenever `frame_pos` is 619 or more (three lines before the nominal frame pulse at half-line 625), and whenever `vdrive` is high. Otherwise it is low.
- R9: `pll_inhibit` is high whenever `frame_pos` is 621 or more, and whenever `vdrive` is high with `frame_pos` below 10. Otherwise it is low.
- R10: At each restart, `field_odd` loads 1 if `line_strobe` was low on the restarting tick and 0 if it was high. It holds that value until the next restart.
- R11: An accepted sync stays pending across any number of cycles without `half_tick`. It takes effect only on the next tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| half_tick | input | 1 | One-cycle strobe every half-line (32 µs) |
| line_strobe | input | 1 | High together with `half_tick` when that tick begins a line |
| vsync_det | input | 1 | One-cycle strobe from the vertical sync detector |
| vid_ok | input | 1 | Video identified; selects the wide window |
| win_open | output | 1 | Sync search window is open |
| vdrive | output | 1 | Vertical drive pulse, 21 half-lines |
| pll_short | output | 1 | Line PLL short time-constant select |
| pll_inhibit | output | 1 | Line PLL inhibit |
| field_odd | output | 1 | Last restart fell mid-line |
| frame_pos | output | 10 | Half-lines since the last restart |

## Verification
A wrong count, a missed pending sync or a wrong window edge all show up as a change in the spacing between `vdrive` rising edges, measured in half-ticks. That spacing also sits on `frame_pos`, so an error is visible on the next tick after it happens. A faulty pulse-length compare shows at the end of the same frame's vertical pulse, within 21 ticks. Errors in the strobe decode show at the exact `frame_pos` values 9, 10, 21, 618 to 621 and at the window edges, so the bench samples those points in every frame.

// File: rtl/fsw_pkg.sv
package fsw_pkg;
  // half-lines elapsed at the start of a given line
  function automatic int unsigned hl_of_line(input int unsigned line);
    return 2 * line;
  endfunction

  // last half-line count still inside the window
  function automatic int unsigned last_open_hl(input int unsigned far_line);
    return 2 * far_line - 1;
  endfunction

  // counter width able to hold every half-line up to far_line
  function automatic int unsigned pos_width(input int unsigned far_line);
    return $clog2(2 * far_line);
  endfunction
endpackage

// File: rtl/fsw_window_decode.sv
module fsw_window_decode #(
  parameter int unsigned CNT_W = 10,
  parameter int unsigned OPEN_LINE = 248,
  parameter int unsigned FAR_LINE_OFF = 314,
  parameter int unsigned FAR_LINE_ON = 352
) (
  input  logic [CNT_W-1:0] pos,
  input  logic             vid_ok,
  output logic             win_open,
  output logic             at_far_edge
);
  import fsw_pkg::*;

  localparam logic [CNT_W-1:0] OPEN_HL  = CNT_W'(hl_of_line(OPEN_LINE));
  localparam logic [CNT_W-1:0] LAST_OFF = CNT_W'(last_open_hl(FAR_LINE_OFF));
  localparam logic [CNT_W-1:0] LAST_ON  = CNT_W'(last_open_hl(FAR_LINE_ON));

  logic [CNT_W-1:0] last_hl;

  always_comb begin
    last_hl     = vid_ok ? LAST_ON : LAST_OFF;
    win_open    = (pos >= OPEN_HL) && (pos <= last_hl);
    at_far_edge = (pos >= last_hl);
  end
endmodule

// File: rtl/fsw_halfline_counter.sv
module fsw_halfline_counter #(
  parameter int unsigned CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             half_tick,
  input  logic             vsync_det,
  input  logic             win_open,
  input  logic             at_far_edge,
  output logic [CNT_W-1:0] pos,
  output logic             sync_pend,
  output logic             restart
);
  assign restart = half_tick && (sync_pend || at_far_edge);

  always_ff @(posedge clk) begin
    if (rst) begin
      pos       <= '0;
      sync_pend <= 1'b0;
    end else begin
      if (restart)        pos <= '0;
      else if (half_tick) pos <= pos + 1'b1;

      if (half_tick && sync_pend)    sync_pend <= 1'b0;
      else if (vsync_det && win_open) sync_pend <= 1'b1;
    end
  end
endmodule

// File: rtl/fsw_service_strobes.sv
module fsw_service_strobes #(
  parameter int unsigned CNT_W = 10,
  parameter int unsigned VD_HALFLINES = 21,
  parameter int unsigned EXPECT_HL = 625,
  parameter int unsigned SHORT_LEAD_HL = 6,
  parameter int unsigned INH_LEAD_HL = 4,
  parameter int unsigned INH_TAIL_HL = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             half_tick,
  input  logic             line_strobe,
  input  logic             restart,
  input  logic [CNT_W-1:0] pos,
  output logic             vdrive,
  output logic             pll_short,
  output logic             pll_inhibit,
  output logic             field_odd
);
  localparam logic [CNT_W-1:0] VD_LAST    = CNT_W'(VD_HALFLINES - 1);
  localparam logic [CNT_W-1:0] SHORT_FROM = CNT_W'(EXPECT_HL - SHORT_LEAD_HL);
  localparam logic [CNT_W-1:0] INH_FROM   = CNT_W'(EXPECT_HL - INH_LEAD_HL);
  localparam logic [CNT_W-1:0] INH_TAIL   = CNT_W'(INH_TAIL_HL);

  always_ff @(posedge clk) begin
    if (rst) begin
      vdrive    <= 1'b0;
      field_odd <= 1'b0;
    end else begin
      if (restart)                           vdrive <= 1'b1;
      else if (half_tick && pos == VD_LAST)  vdrive <= 1'b0;
      if (restart) field_odd <= ~line_strobe;
    end
  end

  always_comb begin
    pll_short   = (pos >= SHORT_FROM) || vdrive;
    pll_inhibit = (pos >= INH_FROM) || (vdrive && pos < INH_TAIL);
  end
endmodule

// File: rtl/fsw_frame_timer.sv
module fsw_frame_timer #(
  parameter int unsigned OPEN_LINE = 248,
  parameter int unsigned FAR_LINE_OFF = 314,
  parameter int unsigned FAR_LINE_ON = 352,
  parameter int unsigned VD_HALFLINES = 21,
  parameter int unsigned EXPECT_HL = 625,
  parameter int unsigned SHORT_LEAD_HL = 6,
  parameter int unsigned INH_LEAD_HL = 4,
  parameter int unsigned INH_TAIL_HL = 10,
  parameter int unsigned CNT_W = fsw_pkg::pos_width(FAR_LINE_ON)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             half_tick,
  input  logic             line_strobe,
  input  logic             vsync_det,
  input  logic             vid_ok,
  output logic             win_open,
  output logic             vdrive,
  output logic             pll_short,
  output logic             pll_inhibit,
  output logic             field_odd,
  output logic [CNT_W-1:0] frame_pos
);
  // named internal events, visible to the bound checker
  logic at_far_edge;
  logic sync_pend;
  logic restart;

  fsw_window_decode #(
    .CNT_W(CNT_W), .OPEN_LINE(OPEN_LINE),
    .FAR_LINE_OFF(FAR_LINE_OFF), .FAR_LINE_ON(FAR_LINE_ON)
  ) win_i (
    .pos(frame_pos), .vid_ok(vid_ok),
    .win_open(win_open), .at_far_edge(at_far_edge)
  );

  fsw_halfline_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk(clk), .rst(rst), .half_tick(half_tick), .vsync_det(vsync_det),
    .win_open(win_open), .at_far_edge(at_far_edge),
    .pos(frame_pos), .sync_pend(sync_pend), .restart(restart)
  );

  fsw_service_strobes #(
    .CNT_W(CNT_W), .VD_HALFLINES(VD_HALFLINES), .EXPECT_HL(EXPECT_HL),
    .SHORT_LEAD_HL(SHORT_LEAD_HL), .INH_LEAD_HL(INH_LEAD_HL),
    .INH_TAIL_HL(INH_TAIL_HL)
  ) svc_i (
    .clk(clk), .rst(rst), .half_tick(half_tick), .line_strobe(line_strobe),
    .restart(restart), .pos(frame_pos),
    .vdrive(vdrive), .pll_short(pll_short), .pll_inhibit(pll_inhibit),
    .field_odd(field_odd)
  );
endmodule

// File: rtl/fsw_frame_timer_chk.sv
module fsw_frame_timer_chk #(
  parameter int unsigned CNT_W = 10,
  parameter int unsigned FAR_LINE_ON = 352
) (
  input logic             clk,
  input logic             rst,
  input logic             half_tick,
  input logic             vsync_det,
  input logic             win_open,
  input logic             vdrive,
  input logic             pll_short,
  input logic             pll_inhibit,
  input logic             field_odd,
  input logic             restart,
  input logic             sync_pend,
  input logic [CNT_W-1:0] frame_pos
);
  localparam logic [CNT_W-1:0] POS_LIMIT = CNT_W'(2 * FAR_LINE_ON);

  // R1
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (frame_pos == '0 && !vdrive && !pll_short && !pll_inhibit && !field_odd));

  // R2
  pos_holds_chk: assert property (@(posedge clk) disable iff (rst)
    !half_tick |=> $stable(frame_pos));

  // R3
  restart_zero_chk: assert property (@(posedge clk) disable iff (rst)
    restart |=> (frame_pos == '0 && vdrive));

  // R4
  pos_bounded_chk: assert property (@(posedge clk) disable iff (rst)
    frame_pos < POS_LIMIT);

  // R7
  vdrive_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(vdrive) |-> $past(restart));

  // R8
  short_in_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    vdrive |-> pll_short);

  // R11
  pend_source_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sync_pend) |-> $past(vsync_det && win_open));
endmodule

bind fsw_frame_timer fsw_frame_timer_chk #(
  .CNT_W(CNT_W), .FAR_LINE_ON(FAR_LINE_ON)
) chk_i (
  .clk(clk), .rst(rst), .half_tick(half_tick), .vsync_det(vsync_det),
  .win_open(win_open), .vdrive(vdrive), .pll_short(pll_short),
  .pll_inhibit(pll_inhibit), .field_odd(field_odd), .restart(restart),
  .sync_pend(sync_pend), .frame_pos(frame_pos)
);

// File: tb/fsw_frame_timer_tb.sv
`timescale 1ns/1ps
module fsw_frame_timer_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic half_tick = 1'b0, line_strobe = 1'b0, vsync_det = 1'b0, vid_ok = 1'b0;
  logic win_open, vdrive, pll_short, pll_inhibit, field_odd;
  logic [9:0] frame_pos;

  int n_run = 0, n_fail = 0, tk = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  fsw_frame_timer dut_i (
    .clk(clk), .rst(rst), .half_tick(half_tick), .line_strobe(line_strobe),
    .vsync_det(vsync_det), .vid_ok(vid_ok), .win_open(win_open),
    .vdrive(vdrive), .pll_short(pll_short), .pll_inhibit(pll_inhibit),
    .field_odd(field_odd), .frame_pos(frame_pos)
  );

  // vectors: video flag, half-line count at which sync is sent (-1 none),
  // expected half-ticks from reset to the vdrive rise
  localparam int VEC_N = 10;
  localparam int V_VID [VEC_N] = '{0,   0,   0,   0,   0,   1,   1,   1,   1,   0};
  localparam int V_SYN [VEC_N] = '{496, 495, 600, 555, -1,  650, 100, 496, -1,  627};
  localparam int V_EXP [VEC_N] = '{497, 628, 601, 556, 628, 651, 704, 497, 704, 628};

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d (pos %0d)", req, act, exp, frame_pos);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; half_tick = 0; line_strobe = 0; vsync_det = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    tk = 0;
  endtask

  // one half-line tick; line_strobe marks even-numbered ticks as line starts
  task automatic tick_once();
    @(negedge clk);
    half_tick = 1'b1;
    line_strobe = (tk % 2 == 0);
    @(negedge clk);
    half_tick = 1'b0;
    line_strobe = 1'b0;
    tk++;
  endtask

  task automatic send_sync();
    vsync_det = 1'b1;
    @(negedge clk);
    vsync_det = 1'b0;
  endtask

  task automatic run_vector(input int vid, input int syn, input int exp);
    int n = 0;
    int w = 1;
    bit found = 0;
    int far_last = vid ? 703 : 627;
    do_reset();
    vid_ok = vid[0];
    for (int i = 0; i < 800 && !found; i++) begin
      if (syn >= 0 && int'(frame_pos) == syn) send_sync();
      tick_once();
      n++;
      if (vdrive) found = 1;
      else begin
        if (frame_pos == 10'd495) chk(vid ? "R4 window shut" : "R3 window shut", win_open, 0);
        if (frame_pos == 10'd496) chk(vid ? "R4 window open" : "R3 window open", win_open, 1);
        if (int'(frame_pos) == far_last) chk(vid ? "R4 far edge open" : "R3 far edge open", win_open, 1);
        if (frame_pos == 10'd618) chk("R8 short before", pll_short, 0);
        if (frame_pos == 10'd619) chk("R8 short start", pll_short, 1);
        if (frame_pos == 10'd620) chk("R9 inhibit before", pll_inhibit, 0);
        if (frame_pos == 10'd621) chk("R9 inhibit start", pll_inhibit, 1);
      end
    end
    if (syn >= 0 && exp == syn + 1) chk("R3 sync period", n, exp);
    else if (syn >= 0)              chk("R5 ignored sync period", n, exp);
    else                            chk("R6 free-run period", n, exp);
    chk("R10 field parity", field_odd, (exp - 1) % 2);
    chk("R3 restart pos", frame_pos, 0);
    chk("R8 short in pulse", pll_short, 1);
    chk("R9 inhibit in pulse", pll_inhibit, 1);
    for (int k = 1; k <= 22; k++) begin
      tick_once();
      chk("R2 count step", frame_pos, k);
      if (vdrive) w++;
      if (k == 9)  chk("R9 inhibit tail", pll_inhibit, 1);
      if (k == 10) chk("R9 inhibit end", pll_inhibit, 0);
      if (k == 21) chk("R8 short end", pll_short, 0);
    end
    chk("R7 vdrive width", w, 21);
    chk("R10 field held", field_odd, (exp - 1) % 2);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog: got 0 expected 1 (run did not end)");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset();
    @(negedge clk);
    chk("R1 pos", frame_pos, 0);
    chk("R1 vdrive", vdrive, 0);
    chk("R1 short", pll_short, 0);
    chk("R1 inhibit", pll_inhibit, 0);
    chk("R1 field", field_odd, 0);
    chk("R1 window", win_open, 0);

    for (int v = 0; v < VEC_N; v++) run_vector(V_VID[v], V_SYN[v], V_EXP[v]);

    // R11: pending sync waits for the tick, count holds meanwhile (R2)
    do_reset();
    vid_ok = 1'b0;
    for (int i = 0; i < 500; i++) tick_once();
    send_sync();
    repeat (5) @(negedge clk);
    chk("R11 held pos", frame_pos, 500);
    chk("R11 no early pulse", vdrive, 0);
    tick_once();
    chk("R11 restart pos", frame_pos, 0);
    chk("R11 pulse", vdrive, 1);

    // R1: reset in mid-pulse clears everything
    tick_once();
    rst = 1'b1;
    @(negedge clk);
    chk("R1 mid reset pos", frame_pos, 0);
    chk("R1 mid reset vdrive", vdrive, 0);
    rst = 1'b0;

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule